// File: doc/BRIEF.md
# Lock-In IQ Demodulator

This block is the digital core of a lock-in detector. It accepts a stream of signed 16-bit converter samples and keeps a 32-bit phase accumulator running for its local oscillator. Each accepted sample is multiplied by the cosine and by the sine of the current oscillator phase. The two products then pass through two independent cascades of low-pass IIR stages whose coefficients are shifts.

Samples are grouped into batches whose length is a power of two. A batch-start pulse loads the accumulator's starting phase and per-sample step. Both values are derived from an external reference scaled by a signed harmonic index, so a harmonic of -1 demodulates the fundamental. Only the filter result after the last sample of a batch is presented, together with a one-cycle valid strobe. The earlier results of the batch still advance the filter state.

Top module: `lockin_iq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the phase, the phase step, the batch position, all filter state, both outputs and `out_valid`. After reset, samples taken before any batch-start therefore see phase 0 and step 0, so the sine is 0 and `q_out` stays 0.
- R2: When `batch_start` is high, the phase becomes `phase_offset + ref_phase * harmonic` (low 32 bits, wrapping). A sample accepted in that same cycle uses this phase and counts as the first sample of the batch.
- R3: When `batch_start` is high, the step becomes `ref_freq * harmonic` (low 32 bits). After each accepted sample the phase advances by the step, modulo 2^32.
- R4: The oscillator index is the top LUT_LOG2+2 bits of the phase. Let N = 2^LUT_LOG2 and T[j] = round((2^31-1)·sin(π·j/(2N))) for j = 0..N. For an index with quadrant q (its top two bits) and remainder r (its low LUT_LOG2 bits), the sine is T[r] when q is 0, T[N-r] when q is 1, -T[r] when q is 2 and -T[N-r] when q is 3. The cosine is the sine at index+N, wrapping.
- R5: Each oscillator value is cut to its top 16 bits and multiplied as signed by the sample. The 32-bit product is shifted right arithmetically by 16, and the result is the filter input.
- R6: Each path has ORDER stages. For each stage, with input x, state y and k = `tc_log2` (0..31): d = x - (y >>> k), then y becomes y + d, then the stage output is ((y + d) - (d >>> 1)) >>> k. All arithmetic is 32-bit two's complement. The same k applies to both paths.
- R7: `i_out` comes from the cosine path and `q_out` from the sine path. Each path keeps its own filter state.
- R8: `out_valid` is high for exactly the cycle after the clock edge that accepts batch sample number 2^BATCH_LOG2-1, counted from 0. The count restarts at each batch-start and wraps if samples continue without one. Earlier samples update state but produce no output. `i_out` and `q_out` hold their values between strobes.
- R9: If `msb_align` is 1 when the last sample of a batch is accepted, both presented results are the filter outputs shifted left by 16. If it is 0, they are presented unshifted.
- R10: A cycle with `smp_valid` low and `batch_start` low changes neither the phase, the filter state, the batch position nor the outputs.
- R11: A batch-start in the middle of a batch discards the partial batch. No strobe appears for it, and the next strobe follows the 2^BATCH_LOG2-th sample after the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 16 | Signed sample |
| batch_start | input | 1 | Loads start phase and step, restarts the batch count |
| ref_phase | input | 32 | Reference phase at batch start |
| ref_freq | input | 32 | Reference phase increment per sample |
| phase_offset | input | 32 | Demodulation phase offset |
| harmonic | input | 32 | Signed harmonic index |
| tc_log2 | input | 5 | Log2 filter time constant |
| msb_align | input | 1 | Shift results left by 16 |
| out_valid | output | 1 | One-cycle strobe with each batch result |
| i_out | output | 32 | In-phase result |
| q_out | output | 32 | Quadrature result |

## Verification
The assertions take for granted that BATCH_LOG2 is at least 1. With that, a batch has at least two samples and two strobes can never fall on adjacent cycles. They also take for granted that `rst` is high from time zero for at least two clock edges, so the held-output and strobe-spacing checks start from cleared registers. The stimulus holds reset for three edges and keeps the default batch of four. It mixes isolated batch-start pulses, batch-starts coinciding with samples, mid-batch restarts and random gaps in `smp_valid`. Every strobe is therefore preceded by an accepted sample that the checker's own count places at the end of a batch.

// File: rtl/lockin_iq.sv
module lockin_iq #(
  parameter int BATCH_LOG2 = 2,
  parameter int LUT_LOG2   = 6,
  parameter int ORDER      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_valid,
  input  logic signed [15:0] smp_data,
  input  logic               batch_start,
  input  logic [31:0]        ref_phase,
  input  logic [31:0]        ref_freq,
  input  logic [31:0]        phase_offset,
  input  logic [31:0]        harmonic,
  input  logic [4:0]         tc_log2,
  input  logic               msb_align,
  output logic               out_valid,
  output logic signed [31:0] i_out,
  output logic signed [31:0] q_out
);

  localparam int NQ = 1 << LUT_LOG2;
  localparam int IW = LUT_LOG2 + 2;
  localparam logic [BATCH_LOG2-1:0] LAST = '1;

  logic signed [31:0] qtab [NQ+1];

  for (genvar j = 0; j <= NQ; j++) begin : g_tab
    localparam int TV = $rtoi(2147483647.0 * $sin(1.5707963267948966 * j / NQ) + 0.5);
    assign qtab[j] = TV;
  end

  function automatic logic signed [31:0] lo_at(input logic [IW-1:0] ix);
    logic [LUT_LOG2:0] a;
    a = ix[IW-2] ? (LUT_LOG2+1)'(NQ) - {1'b0, ix[LUT_LOG2-1:0]} : {1'b0, ix[LUT_LOG2-1:0]};
    return ix[IW-1] ? -qtab[a] : qtab[a];
  endfunction

  logic [31:0] ph_q, step_q;
  logic [BATCH_LOG2-1:0] cnt_q;

  wire [31:0] ph_new   = phase_offset + ref_phase * harmonic;
  wire [31:0] step_new = ref_freq * harmonic;
  wire [31:0] ph_cur   = batch_start ? ph_new : ph_q;
  wire [31:0] step_cur = batch_start ? step_new : step_q;
  wire [BATCH_LOG2-1:0] cnt_cur = batch_start ? '0 : cnt_q;

  wire [IW-1:0] ix = ph_cur[31 -: IW];
  wire signed [31:0] lo_c = lo_at(ix + IW'(NQ));
  wire signed [31:0] lo_s = lo_at(ix);
  wire signed [15:0] lc_hi = lo_c[31:16];
  wire signed [15:0] ls_hi = lo_s[31:16];
  wire signed [31:0] prod_i = smp_data * lc_hi;
  wire signed [31:0] prod_q = smp_data * ls_hi;
  wire signed [31:0] mix_i = prod_i >>> 16;
  wire signed [31:0] mix_q = prod_q >>> 16;

  logic signed [31:0] yi_q [ORDER];
  logic signed [31:0] yq_q [ORDER];
  logic signed [31:0] yi_n [ORDER];
  logic signed [31:0] yq_n [ORDER];
  logic signed [31:0] fi, fq;

  always_comb begin
    logic signed [31:0] xi, xq, di, dq;
    xi = mix_i;
    xq = mix_q;
    for (int s = 0; s < ORDER; s++) begin
      di = xi - (yi_q[s] >>> tc_log2);
      dq = xq - (yq_q[s] >>> tc_log2);
      yi_n[s] = yi_q[s] + di;
      yq_n[s] = yq_q[s] + dq;
      xi = (yi_n[s] - (di >>> 1)) >>> tc_log2;
      xq = (yq_n[s] - (dq >>> 1)) >>> tc_log2;
    end
    fi = xi;
    fq = xq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= '0;
      step_q    <= '0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
      i_out     <= '0;
      q_out     <= '0;
      for (int s = 0; s < ORDER; s++) begin
        yi_q[s] <= '0;
        yq_q[s] <= '0;
      end
    end else begin
      out_valid <= 1'b0;
      if (smp_valid) begin
        ph_q   <= ph_cur + step_cur;
        step_q <= step_cur;
        cnt_q  <= cnt_cur + BATCH_LOG2'(1);
        yi_q   <= yi_n;
        yq_q   <= yq_n;
        if (cnt_cur == LAST) begin
          out_valid <= 1'b1;
          i_out     <= msb_align ? fi <<< 16 : fi;
          q_out     <= msb_align ? fq <<< 16 : fq;
        end
      end else if (batch_start) begin
        ph_q   <= ph_new;
        step_q <= step_new;
        cnt_q  <= '0;
      end
    end
  end

endmodule

module lockin_iq_chk #(
  parameter int BATCH_LOG2 = 2
) (
  input logic        clk,
  input logic        rst,
  input logic        smp_valid,
  input logic        batch_start,
  input logic        out_valid,
  input logic [31:0] i_out,
  input logic [31:0] q_out
);

  logic [BATCH_LOG2-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (batch_start) seen <= smp_valid ? BATCH_LOG2'(1) : '0;
    else if (smp_valid) seen <= seen + BATCH_LOG2'(1);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !out_valid);

  // R8
  strobe_needs_sample_chk: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(smp_valid));

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid);

  // R11
  batch_len_chk: assert property (@(posedge clk) disable iff (rst) out_valid |-> seen == '0);

  // R10
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(i_out) && $stable(q_out)));

endmodule

bind lockin_iq lockin_iq_chk #(.BATCH_LOG2(BATCH_LOG2)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .batch_start(batch_start),
  .out_valid(out_valid), .i_out(i_out), .q_out(q_out)
);

// File: tb/test_lockin_iq.sv
module test_lockin_iq;
  localparam int BL = 2, LL = 6, ORD = 2;
  localparam int NB = 1 << BL, NQ = 1 << LL, IW = LL + 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, smp_valid = 1'b0, batch_start = 1'b0, msb_align = 1'b0;
  logic signed [15:0] smp_data = '0;
  logic [31:0] ref_phase = '0, ref_freq = '0, phase_offset = '0, harmonic = '0;
  logic [4:0] tc_log2 = 5'd8;
  logic out_valid;
  logic signed [31:0] i_out, q_out;

  lockin_iq #(.BATCH_LOG2(BL), .LUT_LOG2(LL), .ORDER(ORD)) i_lockin_iq (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .batch_start(batch_start), .ref_phase(ref_phase), .ref_freq(ref_freq),
    .phase_offset(phase_offset), .harmonic(harmonic), .tc_log2(tc_log2),
    .msb_align(msb_align), .out_valid(out_valid), .i_out(i_out), .q_out(q_out)
  );

  int total = 0, bad = 0;
  string req = "R1";
  bit done = 0;

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  int tabv [NQ+1];
  initial for (int j = 0; j <= NQ; j++)
    tabv[j] = $rtoi(2147483647.0 * $sin(1.5707963267948966 * j / NQ) + 0.5);

  function automatic int sine_of(input int i);
    int q, r, v;
    q = i / NQ;
    r = i % NQ;
    v = (q % 2 == 1) ? tabv[NQ - r] : tabv[r];
    return (q >= 2) ? -v : v;
  endfunction

  bit [31:0] m_ph, m_step;
  int m_cnt, m_i, m_q;
  bit m_v;
  int m_y [2][ORD];

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_step = 0; m_cnt = 0; m_i = 0; m_q = 0; m_v = 0;
      for (int p = 0; p < 2; p++) for (int s = 0; s < ORD; s++) m_y[p][s] = 0;
    end else begin
      m_v = 0;
      if (batch_start) begin
        m_ph = phase_offset + ref_phase * harmonic;
        m_step = ref_freq * harmonic;
        m_cnt = 0;
      end
      if (smp_valid) begin
        int idx, k;
        int x [2];
        int lo [2];
        idx = int'(m_ph >> (32 - IW));
        lo[0] = sine_of((idx + NQ) % (4 * NQ));
        lo[1] = sine_of(idx);
        k = int'(tc_log2);
        for (int p = 0; p < 2; p++) begin
          x[p] = (int'(smp_data) * (lo[p] >>> 16)) >>> 16;
          for (int s = 0; s < ORD; s++) begin
            int d;
            d = x[p] - (m_y[p][s] >>> k);
            m_y[p][s] = m_y[p][s] + d;
            x[p] = (m_y[p][s] - (d >>> 1)) >>> k;
          end
        end
        m_ph = m_ph + m_step;
        m_cnt++;
        if (m_cnt == NB) begin
          m_cnt = 0;
          m_v = 1;
          m_i = msb_align ? x[0] << 16 : x[0];
          m_q = msb_align ? x[1] << 16 : x[1];
        end
      end
    end
    #2;
    if (!rst && !done) begin
      chk(req, "out_valid", longint'(out_valid), longint'(m_v));
      if (m_v) begin
        chk(req, "i_out", longint'(i_out), longint'(m_i));
        chk(req, "q_out", longint'(q_out), longint'(m_q));
      end
    end
  end

  task automatic drive(input logic signed [15:0] d, input bit v, input bit bs);
    @(negedge clk);
    smp_data = d;
    smp_valid = v;
    batch_start = bs;
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) drive(16'sd0, 1'b0, 1'b0);
  endtask

  task automatic batch(input bit with_start, input bit start_on_sample, input bit gaps, input int amp);
    if (with_start && !start_on_sample) drive(16'sd0, 1'b0, 1'b1);
    for (int n = 0; n < NB; n++) begin
      if (gaps) while ($urandom_range(0, 2) == 0) drive(16'sd0, 1'b0, 1'b0);
      drive(16'($signed($urandom_range(0, 2 * amp)) - amp), 1'b1,
            with_start && start_on_sample && n == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "out_valid after reset", longint'(out_valid), 0);
    chk("R1", "i_out after reset", longint'(i_out), 0);
    chk("R1", "q_out after reset", longint'(q_out), 0);

    // R1: zero phase and step until the first batch-start
    req = "R1";
    tc_log2 = 5'd2;
    for (int n = 0; n < NB; n++) drive(16'sd20000, 1'b1, 1'b0);
    idle(1);
    #3;
    chk("R1", "q_out with zero phase", longint'(q_out), 0);
    idle(2);

    // R2 R3: start phase and step from harmonic-scaled reference
    req = "R2";
    tc_log2 = 5'd8;
    phase_offset = 32'h4000_0000;
    harmonic = 32'hFFFF_FFFF;
    ref_freq = 32'h0400_0000;
    for (int b = 0; b < 6; b++) begin
      ref_phase = $urandom;
      batch(1, 0, 0, 30000);
      idle(2);
    end
    req = "R3";
    for (int b = 0; b < 6; b++) begin
      ref_phase = $urandom;
      ref_freq = $urandom;
      batch(1, 1, 0, 30000);
    end
    idle(2);

    // R4 R5 R7: phase sweep over all quadrants, full-scale samples
    req = "R4";
    harmonic = 32'd3;
    ref_freq = 32'h0123_4567;
    for (int b = 0; b < 40; b++) begin
      ref_phase = $urandom;
      batch(1, b % 2 == 0, 0, 32767);
    end
    req = "R5";
    for (int b = 0; b < 10; b++) begin
      drive(16'sh8000, 1'b1, 1'b1);
      for (int n = 1; n < NB; n++) drive(16'sh7FFF, 1'b1, 1'b0);
    end
    req = "R7";
    harmonic = 32'd1;
    phase_offset = 32'h0;
    ref_freq = 32'h0;
    ref_phase = 32'h8000_0000;
    for (int b = 0; b < 4; b++) batch(1, 1, 0, 32000);
    idle(2);

    // R6: several time constants
    req = "R6";
    harmonic = 32'hFFFF_FFFE;
    ref_freq = 32'h0777_0000;
    for (int kk = 0; kk < 4; kk++) begin
      tc_log2 = (kk == 0) ? 5'd0 : (kk == 1) ? 5'd3 : (kk == 2) ? 5'd12 : 5'd8;
      for (int b = 0; b < 5; b++) begin
        ref_phase = $urandom;
        batch(1, 0, 0, 32767);
      end
    end
    idle(2);

    // R9: left-aligned results
    req = "R9";
    msb_align = 1'b1;
    for (int b = 0; b < 6; b++) batch(1, 1, 0, 20000);
    msb_align = 1'b0;
    idle(2);

    // R10: gaps in the sample stream
    req = "R10";
    for (int b = 0; b < 12; b++) batch(b % 3 == 0, 0, 1, 25000);
    idle(2);

    // R11: restart in the middle of a batch
    req = "R11";
    for (int b = 0; b < 6; b++) begin
      for (int n = 0; n < 1 + b % (NB - 1); n++) drive(16'sd12345, 1'b1, 1'b0);
      batch(1, b % 2, 0, 30000);
    end

    // R8: free-running batches with no restart
    req = "R8";
    for (int b = 0; b < 20; b++) batch(0, 0, b % 2, 32767);
    idle(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog %s actual=hung expected=finished", req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule